// File: doc/BRIEF.md
# I2C Address Matcher with Reset-Key Sequence

This block sits behind a byte-level I2C receiver and decides, byte by byte, whether the device should acknowledge. It takes the receiver's start, stop and byte-valid strobes together with the received byte. It answers with an acknowledge decision one cycle after each byte. The first byte after a start is checked against several addresses:

- the device's own slave address, built from a fixed three-bit prefix and four hardware pins;
- a broadcast address that is enabled by default;
- a set of group addresses, each with its own enable;
- a reserved reset address.

Every programmable address keeps 100 in bits 7:5 and 0 in bit 0. Only bits 4:1 come in as inputs.

When the reserved reset address arrives in write form, the block expects a fixed two-byte key. It emits a one-cycle reset pulse only at a stop that closes a correct, complete key. Any deviation abandons the sequence without a reset. A start always abandons whatever is in progress and opens a new address phase.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, ack_o, sel_o, rw_o and swreset_o are 0, and no byte is acknowledged until a start and a matching address byte arrive.
- R2: An address byte whose bits 7:1 equal {100, pins_i} is acknowledged in both read and write form. ack_o pulses in the cycle after byte_vld_i. In that same cycle sel_o rises and rw_o shows bit 0 of the byte (1 = read).
- R3: An address byte whose bits 7:1 equal {100, all_addr_i} is acknowledged in both forms only while all_en_i is 1. With all_en_i at 0 it is not acknowledged.
- R4: Group address k compares bits 7:1 against {100, sub_addr_i[4k+3:4k]}. It is acknowledged in both forms only while sub_en_i[k] is 1.
- R5: An address byte that matches nothing is not acknowledged. Every byte after it is also left unacknowledged until the next start.
- R6: While selected in write form, every data byte is acknowledged. While selected in read form, no data byte is acknowledged.
- R7: Bits 7:1 equal to 4Bh form the reset address, and this match takes priority over every other match. 96h is acknowledged and does not raise sel_o. 97h is not acknowledged, and no later byte is acknowledged before the next start.
- R8: After 96h, the first data byte is acknowledged only if it is A5h, and the second only if it is 5Ah. A mismatch, or any byte after the two key bytes, is not acknowledged and cancels the sequence.
- R9: swreset_o is high for exactly one cycle: the cycle after a stop that follows a correct A5h, 5Ah key with no further byte. It stays 0 otherwise.
- R10: A start abandons any sequence and begins a new address phase. If start_i and stop_i are high in the same cycle, the start wins and no reset pulse is issued. A byte_vld_i in a cycle with start_i or stop_i is ignored.
- R11: A stop clears sel_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start condition seen, one-cycle strobe |
| stop_i | input | 1 | Stop condition seen, one-cycle strobe |
| byte_vld_i | input | 1 | A byte has been received, one-cycle strobe |
| byte_i | input | 8 | Received byte |
| pins_i | input | 4 | Hardware address pins, low bits of the slave address |
| all_addr_i | input | 4 | Writable bits 4:1 of the broadcast address |
| all_en_i | input | 1 | Broadcast address enable |
| sub_addr_i | input | 4*SUB_N | Writable bits 4:1 of each group address, group k at [4k+3:4k] |
| sub_en_i | input | SUB_N | Per-group address enable |
| ack_o | output | 1 | Acknowledge decision, a pulse in the cycle after the byte |
| sel_o | output | 1 | Device is selected for a normal transfer |
| rw_o | output | 1 | Read/write bit of the last accepted normal address |
| swreset_o | output | 1 | One-cycle reset request |

## Verification
Closing the key sequence and opening a new transfer can fall in the same cycle. This happens when a start and the stop that would finish a correct A5h, 5Ah key are strobed together. The bench provokes this by driving both strobes in one cycle after a complete key. It then judges swreset_o, expecting it to stay low. It also expects an address byte sent straight afterwards to be acknowledged as a fresh address phase. A second overlap, a byte strobe in the same cycle as a start, is judged by requiring that the byte is neither acknowledged nor allowed to advance the sequence.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int          SUB_N    = 3,
  parameter logic [2:0]  FIX_HI   = 3'b100,
  parameter logic [6:0]  RST_ADDR = 7'h4B,
  parameter logic [7:0]  KEY_A    = 8'hA5,
  parameter logic [7:0]  KEY_B    = 8'h5A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               byte_vld_i,
  input  logic [7:0]         byte_i,
  input  logic [3:0]         pins_i,
  input  logic [3:0]         all_addr_i,
  input  logic               all_en_i,
  input  logic [4*SUB_N-1:0] sub_addr_i,
  input  logic [SUB_N-1:0]   sub_en_i,
  output logic               ack_o,
  output logic               sel_o,
  output logic               rw_o,
  output logic               swreset_o
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SEL, S_K1, S_K2, S_KOK} st_t;

  st_t  st;
  logic ack_q, rw_q, rst_q;
  logic [SUB_N-1:0] sub_hit;

  for (genvar k = 0; k < SUB_N; k++) begin : g_sub
    assign sub_hit[k] = sub_en_i[k] && (byte_i[7:1] == {FIX_HI, sub_addr_i[4*k +: 4]});
  end

  wire is_rst  = byte_i[7:1] == RST_ADDR;
  wire own_hit = byte_i[7:1] == {FIX_HI, pins_i};
  wire all_hit = all_en_i && (byte_i[7:1] == {FIX_HI, all_addr_i});
  wire any_hit = own_hit || all_hit || (|sub_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      ack_q <= 1'b0;
      rw_q  <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      rst_q <= 1'b0;
      if (start_i) begin
        st <= S_ADDR;
      end else if (stop_i) begin
        rst_q <= (st == S_KOK);
        st    <= S_IDLE;
      end else if (byte_vld_i) begin
        case (st)
          S_ADDR: begin
            if (is_rst) begin
              ack_q <= ~byte_i[0];
              st    <= byte_i[0] ? S_IDLE : S_K1;
            end else if (any_hit) begin
              ack_q <= 1'b1;
              rw_q  <= byte_i[0];
              st    <= S_SEL;
            end else begin
              st <= S_IDLE;
            end
          end
          S_SEL: ack_q <= ~rw_q;
          S_K1: begin
            ack_q <= (byte_i == KEY_A);
            st    <= (byte_i == KEY_A) ? S_K2 : S_IDLE;
          end
          S_K2: begin
            ack_q <= (byte_i == KEY_B);
            st    <= (byte_i == KEY_B) ? S_KOK : S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign ack_o     = ack_q;
  assign sel_o     = (st == S_SEL);
  assign rw_o      = rw_q;
  assign swreset_o = rst_q;

endmodule

module i2c_addr_match_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic stop_i,
  input logic byte_vld_i,
  input logic ack_o,
  input logic sel_o,
  input logic swreset_o
);

  assert_ack_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> ($past(byte_vld_i) && !$past(start_i) && !$past(stop_i)));

  assert_sel_needs_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_o) |-> ack_o);

  assert_pulse_after_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    swreset_o |-> ($past(stop_i) && !$past(start_i)));

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    swreset_o |=> !swreset_o);

  assert_no_sel_on_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    swreset_o |-> !sel_o);

  assert_stop_clears_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stop_i) && !$past(start_i)) |-> !sel_o);

endmodule

bind i2c_addr_match i2c_addr_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
  .byte_vld_i(byte_vld_i), .ack_o(ack_o), .sel_o(sel_o), .swreset_o(swreset_o)
);

// File: tb/sim_i2c_addr_match.sv
module sim_i2c_addr_match;
  logic clk = 0, rst_n = 0;
  logic start_i = 0, stop_i = 0, byte_vld_i = 0;
  logic [7:0] byte_i = 0;
  logic [3:0] pins_i = 4'b0101, all_addr_i = 4'b1000;
  logic all_en_i = 1;
  logic [11:0] sub_addr_i = {4'b1100, 4'b1010, 4'b1001};
  logic [2:0] sub_en_i = 3'b000;
  logic ack_o, sel_o, rw_o, swreset_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  i2c_addr_match u0 (.clk, .rst_n, .start_i, .stop_i, .byte_vld_i, .byte_i, .pins_i,
    .all_addr_i, .all_en_i, .sub_addr_i, .sub_en_i, .ack_o, .sel_o, .rw_o, .swreset_o);

  // behavioural reference: phase 0 idle, 1 address, 2 selected, 3 key1, 4 key2, 5 key done
  int ph = 0;
  bit e_ack = 0, e_rw = 0, e_rst = 0;
  always @(posedge clk) begin
    bit hit;
    if (!rst_n) begin ph = 0; e_ack = 0; e_rw = 0; e_rst = 0; end
    else begin
      e_ack = 0; e_rst = 0;
      if (start_i) ph = 1;
      else if (stop_i) begin e_rst = (ph == 5); ph = 0; end
      else if (byte_vld_i) begin
        if (ph == 1) begin
          hit = (byte_i[7:1] == {3'b100, pins_i}) ||
                (all_en_i && byte_i[7:1] == {3'b100, all_addr_i});
          for (int k = 0; k < 3; k++)
            if (sub_en_i[k] && byte_i[7:1] == {3'b100, sub_addr_i[4*k +: 4]}) hit = 1;
          if (byte_i[7:1] == 7'h4B) begin e_ack = !byte_i[0]; ph = byte_i[0] ? 0 : 3; end
          else if (hit) begin e_ack = 1; e_rw = byte_i[0]; ph = 2; end
          else ph = 0;
        end else if (ph == 2) e_ack = !e_rw;
        else if (ph == 3) begin e_ack = (byte_i == 8'hA5); ph = e_ack ? 4 : 0; end
        else if (ph == 4) begin e_ack = (byte_i == 8'h5A); ph = e_ack ? 5 : 0; end
        else ph = 0;
      end
    end
  end

  task automatic chk(input string rq, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", rq, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R2 ack_o model", ack_o, e_ack);
    chk("R11 sel_o model", sel_o, ph == 2);
    chk("R2 rw_o model", rw_o, e_rw);
    chk("R9 swreset_o model", swreset_o, e_rst);
  end

  task automatic pulse(input bit s, input bit p, input bit v, input logic [7:0] b);
    start_i = s; stop_i = p; byte_vld_i = v; byte_i = b;
    @(negedge clk);
    start_i = 0; stop_i = 0; byte_vld_i = 0;
  endtask
  task automatic st();                    pulse(1, 0, 0, 8'h00); @(negedge clk); endtask
  task automatic sp();                    pulse(0, 1, 0, 8'h00); endtask
  task automatic by(input logic [7:0] b); pulse(0, 0, 1, b);     endtask

  initial begin
    fork
      begin #1_000_000; errors++; $display("FAIL watchdog expired"); end
      begin
        repeat (3) @(negedge clk);
        chk("R1 ack after reset", ack_o, 0);
        chk("R1 sel after reset", sel_o, 0);
        chk("R1 swreset after reset", swreset_o, 0);
        rst_n = 1; @(negedge clk);
        by(8'h8A); chk("R1 no ack without start", ack_o, 0);
        st(); by(8'h8A); chk("R2 own write ack", ack_o, 1); chk("R2 sel", sel_o, 1); chk("R2 rw write", rw_o, 0);
        @(negedge clk); by(8'h33); chk("R6 write data ack", ack_o, 1);
        sp(); chk("R11 stop clears sel", sel_o, 0);
        st(); by(8'h8B); chk("R2 own read ack", ack_o, 1); chk("R2 rw read", rw_o, 1);
        @(negedge clk); by(8'h33); chk("R6 read data no ack", ack_o, 0); sp();
        st(); by(8'h90); chk("R3 broadcast write ack", ack_o, 1); sp();
        st(); by(8'h91); chk("R3 broadcast read ack", ack_o, 1); sp();
        all_en_i = 0;
        st(); by(8'h90); chk("R3 broadcast disabled", ack_o, 0); sp();
        st(); by(8'h92); chk("R4 group disabled", ack_o, 0); sp();
        sub_en_i = 3'b010;
        st(); by(8'h94); chk("R4 group1 write ack", ack_o, 1); sp();
        st(); by(8'h95); chk("R4 group1 read ack", ack_o, 1); sp();
        st(); by(8'h98); chk("R4 group2 disabled", ack_o, 0); sp();
        st(); by(8'h70); chk("R5 no match", ack_o, 0); chk("R5 no sel", sel_o, 0);
        @(negedge clk); by(8'h8A); chk("R5 later byte nack", ack_o, 0); sp();
        st(); by(8'h96); chk("R7 reset addr ack", ack_o, 1); chk("R7 no sel", sel_o, 0);
        @(negedge clk); by(8'hA5); chk("R8 key A ack", ack_o, 1);
        @(negedge clk); by(8'h5A); chk("R8 key B ack", ack_o, 1);
        sp(); chk("R9 pulse", swreset_o, 1);
        @(negedge clk); chk("R9 single cycle", swreset_o, 0);
        st(); by(8'h97); chk("R7 read form nack", ack_o, 0);
        @(negedge clk); by(8'hA5); chk("R7 no key after read", ack_o, 0); sp(); chk("R9 no pulse read form", swreset_o, 0);
        st(); by(8'h96); @(negedge clk); by(8'hA4); chk("R8 wrong key A", ack_o, 0);
        @(negedge clk); by(8'h5A); chk("R8 aborted", ack_o, 0); sp(); chk("R9 no pulse mismatch", swreset_o, 0);
        st(); by(8'h96); by(8'hA5); by(8'h5B); chk("R8 wrong key B", ack_o, 0); sp(); chk("R9 no pulse keyB", swreset_o, 0);
        st(); by(8'h96); by(8'hA5); by(8'h5A); by(8'h00); chk("R8 extra byte nack", ack_o, 0);
        sp(); chk("R9 no pulse extra", swreset_o, 0);
        st(); by(8'h96); by(8'hA5); st(); by(8'h8A); chk("R10 restart address", ack_o, 1); sp();
        st(); by(8'h96); by(8'hA5); by(8'h5A);
        pulse(1, 1, 0, 8'h00); chk("R10 start beats stop", swreset_o, 0);
        by(8'h8A); chk("R10 fresh address", ack_o, 1); sp();
        st(); by(8'h96); pulse(1, 0, 1, 8'hA5); chk("R10 byte with start ignored", ack_o, 0);
        by(8'hA5); chk("R10 key byte not consumed", ack_o, 0); sp();
        pins_i = 4'b1011;
        st(); by(8'h96); chk("R7 priority ack", ack_o, 1); chk("R7 priority no sel", sel_o, 0);
        by(8'hA5); chk("R7 priority key path", ack_o, 1); sp();
        repeat (3) @(negedge clk);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule